// File: doc/BRIEF.md
# Retriggerable One-Pulse Timer

This block turns an edge on a trigger input into a single timed pulse. It is built around an up-counter that sits at zero until the selected trigger edge arrives. In the delayed-pulse flavour, the counter starts on the edge. The output goes active once the counter reaches the compare value and stays active until the counter reaches the reload value. The counter then either stops (single shot) or wraps and keeps generating pulses (repeating).

In the retriggerable flavour, the output goes active on the first counted cycle and lasts for reload cycles. Any further trigger edge that arrives while the pulse is running clears the counter, so the pulse is stretched rather than the edge being lost. The trigger passes through a synchroniser and an edge detector whose polarity is selectable. A level enable gates all trigger edges and aborts a running pulse.

The sequencer has three named states:
- `ST_IDLE`: the counter is held at zero.
- `ST_ONESHOT`: delayed-pulse run.
- `ST_RETRIG`: retriggerable run.

Its transitions are:
- `ST_IDLE`→`ST_ONESHOT` or `ST_RETRIG`: an accepted edge, chosen by the mode.
- `ST_ONESHOT`→`ST_ONESHOT` (wrap): repeating mode at the last count.
- `ST_ONESHOT`→`ST_IDLE`: single mode at the last count.
- `ST_RETRIG`→`ST_RETRIG` (restart): a new edge.
- `ST_RETRIG`→`ST_IDLE`: the last count.
- Any run state→`ST_IDLE`: enable low.

Top module: `rpt_pulse_timer`

## Requirements
- R1: After reset the output is low, the count is 0 and the sequencer is idle.
- R2: The trigger is synchronised through two flops. With `trig_fall`=0 only rising edges count, and with `trig_fall`=1 only falling edges count. The count reads 0 in a run state on the third rising clock after the trigger level changes.
- R3: In mode 2'b00 (single), the count runs 0 to reload-1. The output is high while compare ≤ count < reload, giving a delay of compare cycles and a length of reload−compare cycles. The block then returns to idle with count 0. If compare ≥ reload, no pulse is produced.
- R4: In mode 2'b01 (repeating), the count wraps from reload-1 to 0 and keeps running. The output is high whenever count ≥ compare.
- R5: In modes 2'b00 and 2'b01, trigger edges that arrive during a run have no effect on the count or the output.
- R6: In modes 2'b10 and 2'b11 (retriggerable), the output is high from the first counted cycle for reload cycles, and compare is not used.
- R7: In retriggerable mode, an edge during a run clears the count to 0 on the next clock. A second edge t cycles after the first therefore yields reload+min(t, reload) high cycles in total.
- R8: A reload value of 0 starts no run and produces no pulse.
- R9: While `en` is low, trigger edges are ignored. Dropping `en` during a run returns the block to idle with count 0 and the output low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; gates edges and aborts a run when low |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_fall | input | 1 | Edge select: 0 rising, 1 falling |
| mode | input | 2 | 00 single, 01 repeating, 1x retriggerable |
| reload | input | CNT_W | Run length in cycles |
| compare | input | CNT_W | Delay before the output goes active (delayed-pulse modes) |
| pulse_out | output | 1 | Pulse output |
| count_out | output | CNT_W | Current counter value |

## Verification
The counter-bound and step properties assume that `reload` does not change on the cycle being checked. The stimulus only alters `reload` and `compare` between cases, while the block is idle. The edge detector assumes that `trig_fall` is changed only while the synchronised trigger is steady. The bench therefore switches polarity with the trigger held low and waits before driving edges. Trigger pulses are always held for a full clock and separated by at least one low clock, so that no edge is lost in the synchroniser.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ONESHOT = 2'd1,
        ST_RETRIG  = 2'd2
    } rpt_state_e;

    localparam logic [1:0] MODE_SINGLE = 2'b00;
    localparam logic [1:0] MODE_REPEAT = 2'b01;
endpackage

// File: rtl/rpt_trig_edge.sv
module rpt_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic fall_sel,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= trig_in;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
            prev_q <= synced;
        end
    end

    always_comb begin
        if (fall_sel) edge_o = ~synced & prev_q;
        else          edge_o = synced & ~prev_q;
    end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
    import rpt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig_edge,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] compare,
    output logic             pulse_o,
    output logic [CNT_W-1:0] count_o,
    output rpt_state_e       state_o
);
    rpt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             last_cnt;
    logic             reload_nz;

    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign last_cnt  = cnt_inc >= {1'b0, reload};
    assign reload_nz = |reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (en && trig_edge && reload_nz) begin
                    state_d = mode[1] ? ST_RETRIG : ST_ONESHOT;
                end
            end
            ST_ONESHOT: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (last_cnt) begin
                    cnt_d = '0;
                    if (mode != MODE_REPEAT) state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            ST_RETRIG: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (trig_edge && reload_nz) begin
                    cnt_d = '0;
                end else if (last_cnt) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    pulse_o = 1'b0;
            ST_ONESHOT: pulse_o = (cnt_q >= compare) && (cnt_q < reload);
            ST_RETRIG:  pulse_o = cnt_q < reload;
            default:    pulse_o = 1'b0;
        endcase
    end

    assign count_o = cnt_q;
    assign state_o = state_q;
endmodule

// File: rtl/rpt_pulse_timer.sv
module rpt_pulse_timer
    import rpt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig_in,
    input  logic             trig_fall,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] compare,
    output logic             pulse_out,
    output logic [CNT_W-1:0] count_out
);
    logic       trig_edge;
    rpt_state_e seq_state;

    rpt_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .fall_sel (trig_fall),
        .edge_o   (trig_edge)
    );

    rpt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .trig_edge (trig_edge),
        .mode      (mode),
        .reload    (reload),
        .compare   (compare),
        .pulse_o   (pulse_out),
        .count_o   (count_out),
        .state_o   (seq_state)
    );
endmodule

// File: rtl/rpt_pulse_timer_chk.sv
module rpt_pulse_timer_chk
    import rpt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             trig_edge,
    input logic [CNT_W-1:0] reload,
    input logic             pulse_out,
    input logic [CNT_W-1:0] count_out,
    input rpt_state_e       seq_state
);
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out != '0) |-> (count_out == CNT_W'($past(count_out) + 1'b1)));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out != '0 && $stable(reload)) |-> (count_out < reload));

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RETRIG && en && trig_edge && reload != '0)
        |=> (count_out == '0 && seq_state == ST_RETRIG));

    a_r8_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && reload == '0) |=> (seq_state == ST_IDLE));

    a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (seq_state == ST_IDLE && count_out == '0 && !pulse_out));
endmodule

bind rpt_pulse_timer rpt_pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .trig_edge (trig_edge),
    .reload    (reload),
    .pulse_out (pulse_out),
    .count_out (count_out),
    .seq_state (seq_state)
);

// File: tb/rpt_pulse_timer_tb.sv
module rpt_pulse_timer_tb;
    localparam int CW = 8;
    localparam int NS = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          trig = 1'b0;
    logic          pol = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] rl = '0;
    logic [CW-1:0] cmp = '0;
    logic          pulse;
    logic [CW-1:0] cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rpt_pulse_timer #(.CNT_W(CW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .trig_in   (trig),
        .trig_fall (pol),
        .mode      (mode),
        .reload    (rl),
        .compare   (cmp),
        .pulse_out (pulse),
        .count_out (cnt)
    );

    task automatic chk(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Expected count: a run starts at sample 3 (two sync flops + edge register, R2).
    function automatic int exp_cnt(int md, int r, int t2, int kill, int en_c, int j);
        int rel;
        int s2;
        if (en_c == 0 || r == 0) return 0;
        if (kill != 0 && j > kill) return 0;
        rel = j - 3;
        s2  = t2 + 3;
        if (rel < 0) return 0;
        if (md >= 2) begin
            if (t2 != 0 && j >= s2) return (j - s2 < r) ? j - s2 : 0;
            return (rel < r) ? rel : 0;
        end
        if (md == 1) return rel % r;
        return (rel < r) ? rel : 0;
    endfunction

    function automatic int exp_pls(int md, int r, int c, int t2, int kill, int en_c, int j);
        int rel;
        int s2;
        if (en_c == 0 || r == 0) return 0;
        if (kill != 0 && j > kill) return 0;
        rel = j - 3;
        s2  = t2 + 3;
        if (rel < 0) return 0;
        if (md >= 2) begin
            if (t2 != 0 && j >= s2) return (j - s2 < r) ? 1 : 0;
            return (rel < r) ? 1 : 0;
        end
        if (md == 1) return ((rel % r) >= c) ? 1 : 0;
        return (rel < r && rel >= c) ? 1 : 0;
    endfunction

    task automatic run_case(int md, int r, int c, int t2, int kill, int en_c, string tag);
        logic act;
        act  = ~pol;
        mode = 2'(md);
        rl   = CW'(r);
        cmp  = CW'(c);
        en   = (en_c != 0);
        for (int j = 1; j <= NS; j++) begin
            int i;
            int ep;
            int ec;
            i = j - 1;
            if (i == 0) trig = act;
            if (i == 1) trig = ~act;
            if (t2 != 0 && i == t2) trig = act;
            if (t2 != 0 && i == t2 + 1) trig = ~act;
            if (kill != 0 && i == kill) en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            ep = exp_pls(md, r, c, t2, kill, en_c, j);
            ec = exp_cnt(md, r, t2, kill, en_c, j);
            chk(int'(pulse) == ep,
                $sformatf("%s pulse j=%0d md=%0d r=%0d c=%0d t2=%0d", tag, j, md, r, c, t2),
                int'(pulse), ep);
            chk(int'(cnt) == ec,
                $sformatf("%s count j=%0d md=%0d r=%0d c=%0d t2=%0d", tag, j, md, r, c, t2),
                int'(cnt), ec);
        end
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pulse == 1'b0, "R1 reset pulse", int'(pulse), 0);
        chk(cnt == '0, "R1 reset count", int'(cnt), 0);
        en = 1'b1;

        // R3 / R8: single shot over reload and compare
        for (int r = 0; r <= 6; r++)
            for (int c = 0; c <= 7; c++)
                run_case(0, r, c, 0, 0, 1, (r == 0) ? "R8" : "R3");

        // R6 / R7: retriggerable, second edge at t2
        for (int r = 0; r <= 6; r++) begin
            run_case(2, r, 3, 0, 0, 1, (r == 0) ? "R8" : "R6");
            for (int t2 = 2; t2 <= 8; t2++)
                run_case(3, r, 0, t2, 0, 1, (r == 0) ? "R8" : "R7");
        end

        // R5: edges during a delayed-pulse run are ignored
        for (int r = 3; r <= 6; r++)
            for (int t2 = 2; t2 < r; t2++) begin
                run_case(0, r, 1, t2, 0, 1, "R5");
                run_case(1, r, 1, t2, 25, 1, "R5");
            end

        // R4: repeating, stopped by dropping enable
        for (int r = 1; r <= 4; r++)
            for (int c = 0; c <= 3; c++)
                run_case(1, r, c, 0, 25, 1, "R4");

        // R9: abort and disabled triggers
        run_case(0, 6, 0, 0, 5, 1, "R9");
        run_case(2, 6, 0, 0, 4, 1, "R9");
        run_case(0, 4, 0, 0, 0, 0, "R9");
        run_case(2, 4, 0, 0, 0, 0, "R9");

        // R2: falling polarity ignores rising edges
        mode = 2'b00;
        rl   = CW'(4);
        cmp  = CW'(1);
        pol  = 1'b1;
        repeat (4) @(negedge clk);
        trig = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(pulse == 1'b0, "R2 rising ignored pulse", int'(pulse), 0);
            chk(cnt == '0, "R2 rising ignored count", int'(cnt), 0);
        end
        run_case(0, 4, 1, 0, 0, 1, "R2");
        run_case(2, 5, 0, 3, 0, 1, "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule